// File: doc/BRIEF.md
# Two-Frame Half-Duplex SPI Configuration Register Reader

This block is the host side of a register read over a three-wire serial link. The link has one chip select, one clock line and one data line shared by both directions. The clock line also serves the device as an open-collector alert output. For that reason the host drives the clock line only while a read is in progress, and releases it otherwise. A read begins with a one-cycle start pulse that carries a 16-bit command word. The block then runs two transfers, each framed by chip select. The first sends the command to the device. The second collects a 16-bit answer, from which the block extracts the register byte and checks its parity.

The block has no tri-state buffers. It drives pad values and pad enables, and the pad ring combines them. It holds the command line at input for the whole of the answer frame, so the two sides never drive the shared wire at the same time. The serial clock is divided down from the system clock. All four timing windows are counted in system clocks and set by parameters: the half period, the setup time from chip-select fall, the hold time before chip-select rise, and the minimum chip-select high time between frames.

Top module: `spi_cfg_reader`

## Requirements
- R1: Out of reset and while idle: cs_n_o=1, sclk_oe_o=0, sdio_oe_o=0, sclk_o=0, sdio_o=0, busy_o=0, done_o=0, data_o=0 and perr_o=0.
- R2: After an accepted start, the block first drives the clock line low (sclk_oe_o=1, sclk_o=0) for SU_CYC cycles while cs_n_o is still 1. sclk_o is 0 at every chip-select edge.
- R3: In the command frame, cs_n_o=0 and sdio_oe_o=1. sdio_o shows command bit 15 for SU_CYC cycles. The block then gives 16 clock periods, each HALF_CYC cycles low followed by HALF_CYC cycles high. Bits go out most significant first, and each bit changes only when sclk_o falls.
- R4: After the 16th command clock falls, sdio_oe_o drops to 0 at once. cs_n_o stays 0 for HD_CYC cycles and then stays 1 for CSH_CYC cycles.
- R5: In the answer frame, cs_n_o=0 for SU_CYC cycles before the first clock. The frame has 16 clocks shaped as in R3, and sdio_oe_o stays 0 throughout. sdio_i is sampled on the system clock edge on which sclk_o rises.
- R6: Samples 1 to 7 are discarded. Samples 8 to 15 form data_o, most significant bit first. data_o is updated in the cycle of done_o and holds until the next one.
- R7: Sample 16 is the parity bit. perr_o=1 when the 8 data bits together with the parity bit contain an even number of ones (odd parity expected). perr_o is updated and held as data_o is.
- R8: HD_CYC cycles after the last answer clock falls, done_o pulses for one cycle. In that same cycle cs_n_o=1, sclk_oe_o=0 and busy_o=0.
- R9: busy_o is 1 from the cycle after the start until done_o. A start while busy is ignored. cmd_i is captured at the accepted start, and later changes to it have no effect. A start during the done_o cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled when idle |
| cmd_i | input | 16 | Command, address and dummy bits for the first frame |
| sdio_i | input | 1 | Value received on the shared data pad |
| busy_o | output | 1 | Read in progress |
| done_o | output | 1 | One-cycle completion pulse |
| data_o | output | 8 | Last register value read |
| perr_o | output | 1 | Parity error of the last read |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock value for the clock/alert pad |
| sclk_oe_o | output | 1 | Drive enable for the clock/alert pad |
| sdio_o | output | 1 | Value driven on the shared data pad |
| sdio_oe_o | output | 1 | Drive enable for the shared data pad |

## Verification
The bench compares every pin against a timeline model on every cycle. It aims at the points where chip select, the clock and the data enables meet. If the design raised chip select early or skipped the hold count, the frame boundaries would land on the wrong cycles. If it left the data enable on into the hold, it would contend with the device for the shared wire. If it shifted on the wrong clock edge, every command bit would be one half period early. Answers are chosen so that a one-bit slip in the 7-bit dummy skip shows up in data_o, and so that a parity sense inverted in the design flips perr_o for both good and bad parity. Start pulses given during busy and during the done cycle check the accept rule, and a cmd_i changed after the start checks the capture.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int FRAME_BITS = 16;
  localparam int DUMMY_BITS = 7;
  localparam int DATA_BITS  = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE,
    ST_SU1,
    ST_SH1,
    ST_HD1,
    ST_GAP,
    ST_SU2,
    ST_SH2,
    ST_HD2
  } rd_state_t;
endpackage

// File: rtl/spi_cfg_seq.sv
module spi_cfg_seq
  import spi_cfg_pkg::*;
#(
  parameter int HALF_CYC = 4,
  parameter int SU_CYC   = 4,
  parameter int HD_CYC   = 4,
  parameter int CSH_CYC  = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_i,
  output rd_state_t st_o,
  output logic      sclk_o,
  output logic      load_o,
  output logic      shift_o,
  output logic      sample_o,
  output logic      fin_o
);
  localparam int M1   = (HALF_CYC > SU_CYC) ? HALF_CYC : SU_CYC;
  localparam int M2   = (HD_CYC > CSH_CYC) ? HD_CYC : CSH_CYC;
  localparam int MAXV = (M1 > M2) ? M1 : M2;
  localparam int CW   = (MAXV > 1) ? $clog2(MAXV) : 1;
  localparam int BW   = $clog2(FRAME_BITS);
  localparam logic [CW-1:0] HALF_L = CW'(HALF_CYC - 1);
  localparam logic [CW-1:0] SU_L   = CW'(SU_CYC - 1);
  localparam logic [CW-1:0] HD_L   = CW'(HD_CYC - 1);
  localparam logic [CW-1:0] CSH_L  = CW'(CSH_CYC - 1);
  localparam logic [BW-1:0] LAST   = BW'(FRAME_BITS - 1);

  rd_state_t       st_q, st_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [BW-1:0]   bit_q, bit_d;
  logic            sclk_q, sclk_d;
  logic            tick;

  assign tick = (cnt_q == '0);

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    bit_d    = bit_q;
    sclk_d   = sclk_q;
    load_o   = 1'b0;
    shift_o  = 1'b0;
    sample_o = 1'b0;
    fin_o    = 1'b0;
    if (!tick && st_q != ST_IDLE) cnt_d = cnt_q - 1'b1;
    case (st_q)
      ST_IDLE: if (start_i) begin
        st_d   = ST_PRE;
        cnt_d  = SU_L;
        load_o = 1'b1;
      end
      ST_PRE: if (tick) begin
        st_d  = ST_SU1;
        cnt_d = SU_L;
      end
      ST_SU1, ST_SU2: if (tick) begin
        st_d   = (st_q == ST_SU1) ? ST_SH1 : ST_SH2;
        cnt_d  = HALF_L;
        bit_d  = '0;
        sclk_d = 1'b0;
      end
      ST_SH1, ST_SH2: if (tick) begin
        cnt_d = HALF_L;
        if (!sclk_q) begin
          sclk_d   = 1'b1;
          sample_o = (st_q == ST_SH2);
        end else begin
          sclk_d = 1'b0;
          if (bit_q == LAST) begin
            st_d  = (st_q == ST_SH1) ? ST_HD1 : ST_HD2;
            cnt_d = HD_L;
          end else begin
            bit_d   = bit_q + 1'b1;
            shift_o = (st_q == ST_SH1);
          end
        end
      end
      ST_HD1: if (tick) begin
        st_d  = ST_GAP;
        cnt_d = CSH_L;
      end
      ST_GAP: if (tick) begin
        st_d  = ST_SU2;
        cnt_d = SU_L;
      end
      ST_HD2: if (tick) begin
        st_d  = ST_IDLE;
        fin_o = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      sclk_q <= sclk_d;
    end
  end

  assign st_o   = st_q;
  assign sclk_o = sclk_q;

  logic in_frame;
  assign in_frame = (st_q inside {ST_SU1, ST_SH1, ST_HD1, ST_SU2, ST_SH2, ST_HD2});

  p_sclk_low_cs_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_frame) |-> (!sclk_q && $past(!sclk_q)));
  p_sclk_low_cs_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_frame) |-> !sclk_q);
  p_clock_in_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_q |-> (st_q == ST_SH1 || st_q == ST_SH2));
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |=> (st_q != ST_PRE || $past(st_q) == ST_PRE));
endmodule

// File: rtl/spi_cfg_shift.sv
module spi_cfg_shift
  import spi_cfg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_i,
  input  logic [FRAME_BITS-1:0] cmd_i,
  input  logic                  shift_i,
  input  logic                  sample_i,
  input  logic                  sdio_i,
  output logic                  tx_msb_o,
  output logic [FRAME_BITS-1:0] rx_o
);
  logic [FRAME_BITS-1:0] tx_q, tx_d, rx_q, rx_d;
  logic                  tx_en, rx_en;

  assign tx_en = load_i | shift_i;
  assign rx_en = sample_i;

  always_comb begin
    tx_d = load_i ? cmd_i : {tx_q[FRAME_BITS-2:0], 1'b0};
    rx_d = {rx_q[FRAME_BITS-2:0], sdio_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (tx_en) tx_q <= tx_d;
      if (rx_en) rx_q <= rx_d;
    end
  end

  assign tx_msb_o = tx_q[FRAME_BITS-1];
  assign rx_o     = rx_q;

  p_tx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !shift_i) |=> $stable(tx_q));
endmodule

// File: rtl/spi_cfg_result.sv
module spi_cfg_result
  import spi_cfg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fin_i,
  input  logic [FRAME_BITS-1:0] rx_i,
  output logic [DATA_BITS-1:0]  data_o,
  output logic                  perr_o,
  output logic                  done_o
);
  logic [DATA_BITS-1:0] data_q, data_d;
  logic                 perr_q, perr_d, done_q;

  always_comb begin
    data_d = rx_i[DATA_BITS:1];
    perr_d = ~(^rx_i[DATA_BITS:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      perr_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= fin_i;
      if (fin_i) begin
        data_q <= data_d;
        perr_q <= perr_d;
      end
    end
  end

  assign data_o = data_q;
  assign perr_o = perr_q;
  assign done_o = done_q;

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  p_result_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> ($stable(data_q) && $stable(perr_q)));
endmodule

// File: rtl/spi_cfg_reader.sv
module spi_cfg_reader
  import spi_cfg_pkg::*;
#(
  parameter int HALF_CYC = 4,
  parameter int SU_CYC   = 4,
  parameter int HD_CYC   = 4,
  parameter int CSH_CYC  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [15:0] cmd_i,
  input  logic        sdio_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [7:0]  data_o,
  output logic        perr_o,
  output logic        cs_n_o,
  output logic        sclk_o,
  output logic        sclk_oe_o,
  output logic        sdio_o,
  output logic        sdio_oe_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rd_state_t             st;
  logic                  load, shift, sample, fin, tx_msb;
  logic [FRAME_BITS-1:0] rx;

  spi_cfg_seq #(
    .HALF_CYC(HALF_CYC), .SU_CYC(SU_CYC), .HD_CYC(HD_CYC), .CSH_CYC(CSH_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_int_n), .start_i(start_i), .st_o(st), .sclk_o(sclk_o),
    .load_o(load), .shift_o(shift), .sample_o(sample), .fin_o(fin)
  );

  spi_cfg_shift u_shift (
    .clk(clk), .rst_n(rst_int_n), .load_i(load), .cmd_i(cmd_i), .shift_i(shift),
    .sample_i(sample), .sdio_i(sdio_i), .tx_msb_o(tx_msb), .rx_o(rx)
  );

  spi_cfg_result u_res (
    .clk(clk), .rst_n(rst_int_n), .fin_i(fin), .rx_i(rx),
    .data_o(data_o), .perr_o(perr_o), .done_o(done_o)
  );

  assign busy_o    = (st != ST_IDLE);
  assign sclk_oe_o = busy_o;
  assign cs_n_o    = !(st inside {ST_SU1, ST_SH1, ST_HD1, ST_SU2, ST_SH2, ST_HD2});
  assign sdio_oe_o = (st == ST_SU1 || st == ST_SH1);
  assign sdio_o    = sdio_oe_o & tx_msb;

  p_no_drive_answer_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (st == ST_SU2 || st == ST_SH2 || st == ST_HD2) |-> !sdio_oe_o);
  p_drive_inside_cs_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    sdio_oe_o |-> !cs_n_o);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |-> (!busy_o && cs_n_o && !sclk_oe_o));
endmodule

// File: tb/spi_cfg_reader_test.sv
module spi_cfg_reader_test;
  localparam int H   = 2;
  localparam int S   = 3;
  localparam int HD  = 2;
  localparam int CSH = 4;
  localparam int B0  = S;
  localparam int B1  = 2 * S;
  localparam int B2  = B1 + 32 * H;
  localparam int B3  = B2 + HD;
  localparam int B4  = B3 + CSH;
  localparam int B5  = B4 + S;
  localparam int B6  = B5 + 32 * H;
  localparam int TOT = B6 + HD;

  logic clk = 1'b0;
  logic rst_n, start_i, sdio_i;
  logic [15:0] cmd_i;
  logic busy_o, done_o, perr_o, cs_n_o, sclk_o, sclk_oe_o, sdio_o, sdio_oe_o;
  logic [7:0] data_o;

  int checks = 0;
  int errors = 0;
  int k = 0;
  logic [15:0] mcmd = '0, mresp = '0, resp_next = '0;
  logic [7:0] e_data = '0;
  logic e_perr = 1'b0;

  always #4 clk = ~clk;

  spi_cfg_reader #(.HALF_CYC(H), .SU_CYC(S), .HD_CYC(HD), .CSH_CYC(CSH)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_i(cmd_i), .sdio_i(sdio_i),
    .busy_o(busy_o), .done_o(done_o), .data_o(data_o), .perr_o(perr_o),
    .cs_n_o(cs_n_o), .sclk_o(sclk_o), .sclk_oe_o(sclk_oe_o),
    .sdio_o(sdio_o), .sdio_oe_o(sdio_oe_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at k=%0d", req, what, act, exp, k);
    end
  endtask

  task automatic model_step();
    bit e_busy, e_done, e_cs, e_oe, e_sclk, e_sdio, sh1, sh2;
    int j;
    e_busy = (k >= 1 && k <= TOT);
    e_done = (k == TOT + 1);
    e_cs   = !((k > B0 && k <= B3) || (k > B4 && k <= TOT));
    e_oe   = (k > B0 && k <= B2);
    sh1    = (k > B1 && k <= B2);
    sh2    = (k > B5 && k <= B6);
    j      = sh1 ? (k - B1 - 1) : (sh2 ? (k - B5 - 1) : 0);
    e_sclk = (sh1 || sh2) && ((j % (2 * H)) >= H);
    e_sdio = 1'b0;
    if (k > B0 && k <= B1) e_sdio = mcmd[15];
    if (sh1) e_sdio = mcmd[15 - j / (2 * H)];
    if (k == 0) chk("R1", "busy idle", busy_o, 0);
    if (k >= 1 && k <= B0) chk("R2", "cs_n pre", cs_n_o, 1);
    chk("R9", "busy", busy_o, e_busy);
    chk("R8", "done", done_o, e_done);
    chk("R2", "sclk_oe", sclk_oe_o, e_busy);
    chk(k <= B3 ? "R3" : "R4", "cs_n", cs_n_o, e_cs);
    chk(k > B4 ? "R5" : "R3", "sclk", sclk_o, e_sclk);
    chk(k > B2 ? "R5" : "R3", "sdio_oe", sdio_oe_o, e_oe);
    chk("R3", "sdio", sdio_o, e_sdio);
    chk("R6", "data", data_o, e_data);
    chk("R7", "perr", perr_o, e_perr);
    sdio_i = sh2 ? mresp[15 - j / (2 * H)] : 1'b0;
    if ((k == 0 || k == TOT + 1) && start_i) begin
      k = 1;
      mcmd = cmd_i;
      mresp = resp_next;
    end else if (k >= 1 && k <= TOT) begin
      k = k + 1;
      if (k == TOT + 1) begin
        e_data = mresp[8:1];
        e_perr = ~(^mresp[8:0]);
      end
    end else begin
      k = 0;
    end
  endtask

  always @(negedge clk) if (rst_n) model_step();

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic do_read(input logic [15:0] c, input logic [15:0] r);
    resp_next = r;
    cmd_i = c;
    start_i = 1'b1;
    wait_cycles(1);
    start_i = 1'b0;
    cmd_i = ~c;
    wait_cycles(TOT + 2);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; cmd_i = '0; sdio_i = 1'b0;
    #3;
    repeat (3) @(negedge clk);
    chk("R1", "reset cs_n", cs_n_o, 1);
    chk("R1", "reset sclk_oe", sclk_oe_o, 0);
    chk("R1", "reset sdio_oe", sdio_oe_o, 0);
    chk("R1", "reset busy", busy_o, 0);
    chk("R1", "reset done", done_o, 0);
    chk("R1", "reset data", data_o, 0);
    chk("R1", "reset perr", perr_o, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    wait_cycles(6);
    // R6 R7: good odd parity, data 0xB4 (four ones) with parity 1
    do_read(16'hA5C3, {7'h55, 8'hB4, 1'b1});
    // R7: even parity count -> error
    do_read(16'h3C0F, {7'h00, 8'h81, 1'b0});
    // R6: all ones answer, nine ones is odd -> no error
    do_read(16'hFFFF, 16'hFFFF);
    // R9: start pulse mid-transfer must be ignored
    resp_next = {7'h7F, 8'h01, 1'b0};
    cmd_i = 16'h8001; start_i = 1'b1;
    wait_cycles(1);
    start_i = 1'b0; cmd_i = 16'h0000;
    wait_cycles(40);
    cmd_i = 16'h7FFE; start_i = 1'b1;
    wait_cycles(1);
    start_i = 1'b0;
    wait_cycles(TOT);
    // R9: start held into the done cycle is accepted at once
    resp_next = {7'h2A, 8'h5A, 1'b0};
    cmd_i = 16'h1234; start_i = 1'b1;
    while (!done_o) wait_cycles(1);
    cmd_i = 16'hC3A5;
    wait_cycles(1);
    start_i = 1'b0;
    chk("R9", "restart busy", busy_o, 1);
    wait_cycles(TOT + 3);
    chk("R1", "idle after reads", cs_n_o, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule